// File: doc/BRIEF.md
# Multi-mode effective address generator

This block resolves the operand location for a load/store unit. Each request carries a 4-bit mode code, two register indices (a base and an index), a signed immediate or displacement, a 2-bit scale selector and a 2-bit access-size selector. The block reads its internal register file, combines the values as the mode dictates, and returns either an operand value or a byte address on a registered result port. Ten modes are supported: register operand, literal operand, base plus displacement, base only, base plus index, absolute, pointer through memory, post-increment, pre-decrement, and base plus shifted index plus displacement.

Most modes finish one cycle after the request is accepted, and a new request can be taken every cycle. The pointer-through-memory mode issues one read to an external memory at the base register value and waits for the returned word, which becomes the final address. The two stepping modes write the adjusted base register back in the same edge that accepts the request. A write port lets the surrounding pipeline load the register file. When that port and a stepping write target the same register in the same cycle, the stepping write takes priority.

Top module: `eagen_top`

## Requirements
- R1: After reset in_ready is 1, out_valid is 0 and mem_req_valid is 0. A legal request in any mode other than 6 that is accepted (in_valid and in_ready both 1 at a rising edge) gives out_valid=1 with out_illegal=0 in the next cycle, and in_ready stays 1 so that back-to-back requests are taken.
- R2: Mode 0 returns the contents of register in_ra and mode 1 returns in_imm sign-extended to the data width. Both give out_is_addr=0. Every other legal mode gives out_is_addr=1.
- R3: Mode 2 returns reg[in_ra] + sign-extended in_imm. Mode 3 returns reg[in_ra]. Mode 5 returns in_imm zero-extended.
- R4: Mode 4 returns reg[in_ra] + reg[in_rb]. Mode 9 returns reg[in_ra] + (reg[in_rb] << in_scale) + sign-extended in_imm, where in_scale values 0, 1, 2 and 3 mean factors 1, 2, 4 and 8.
- R5: Mode 6 raises mem_req_valid for exactly one cycle, in the cycle after acceptance, with mem_req_addr = reg[in_ra], and holds in_ready at 0 until mem_rsp_valid arrives. In the cycle after mem_rsp_valid the block returns mem_rsp_data with out_valid=1 and out_is_addr=1, and in_ready is 1 again.
- R6: Mode 7 returns reg[in_ra] and then sets reg[in_ra] to reg[in_ra] + (1 << in_size). Mode 8 sets reg[in_ra] to reg[in_ra] - (1 << in_size) and returns that new value. The updated register is seen by the next accepted request. No other mode writes the register file.
- R7: Codes 10 to 15 give out_valid=1 and out_illegal=1 with out_value=0 in the next cycle. They issue no memory request and change no register.
- R8: When a stepping write and an external write (rf_we) target the same register in the same cycle, the stepping result is stored. An external write to a different register in that cycle is also stored.
- R9: While no pointer fetch is outstanding, mem_rsp_valid has no effect and produces no out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_mode | input | 4 | Addressing mode code |
| in_ra | input | IW | Base register index |
| in_rb | input | IW | Index register index |
| in_imm | input | IMM_W | Immediate or displacement |
| in_scale | input | 2 | Index shift amount (x1, x2, x4, x8) |
| in_size | input | 2 | Log2 of access size in bytes, used as step |
| rf_we | input | 1 | External register write enable |
| rf_widx | input | IW | External write register index |
| rf_wdata | input | DW | External write data |
| mem_req_valid | output | 1 | Pointer read request pulse |
| mem_req_addr | output | DW | Pointer read address |
| mem_rsp_valid | input | 1 | Pointer read data valid |
| mem_rsp_data | input | DW | Pointer read data |
| out_valid | output | 1 | Result valid pulse |
| out_value | output | DW | Resolved operand or address |
| out_is_addr | output | 1 | 1 if out_value is an address |
| out_illegal | output | 1 | Mode code was not legal |

## Verification
The bench builds the block with a 32-bit data width, 16 registers and a 16-bit immediate. Because the immediate is narrower than the data path, a negative displacement shows whether sign extension is applied, and an absolute address with its top immediate bit set shows that mode 5 zero-extends. All four scale factors and two access sizes are used, and the stepping modes run against registers whose values cross the sign boundary. The memory model answers the pointer fetch after a latency of several cycles, so the stall of in_ready is visible across more than one cycle.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [3:0] {
    MD_REG  = 4'd0,
    MD_LIT  = 4'd1,
    MD_DISP = 4'd2,
    MD_BASE = 4'd3,
    MD_IDX  = 4'd4,
    MD_ABS  = 4'd5,
    MD_PTR  = 4'd6,
    MD_PINC = 4'd7,
    MD_PDEC = 4'd8,
    MD_SCL  = 4'd9
  } eag_mode_e;

  localparam int unsigned MODE_W     = 4;
  localparam int unsigned MODE_COUNT = 10;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } eag_state_e;

endpackage

// File: rtl/eagen_regfile.sv
module eagen_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  input  logic          se_we,
  input  logic [IW-1:0] se_idx,
  input  logic [DW-1:0] se_data,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_data
);

  logic [DW-1:0] regs [NREG];

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

  // Stepping write always lands; external write lands unless it collides.
  logic ext_ok;
  assign ext_ok = ext_we && !(se_we && (se_idx == ext_idx));

  always_ff @(posedge clk) begin
    if (se_we) regs[se_idx] <= se_data;
    if (ext_ok) regs[ext_idx] <= ext_data;
  end

  // R8
  side_effect_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (se_we && ext_we && (se_idx == ext_idx)) |=> (regs[$past(se_idx)] == $past(se_data)));

  // R8
  ext_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_we && !(se_we && (se_idx == ext_idx))) |=> (regs[$past(ext_idx)] == $past(ext_data)));

endmodule

// File: rtl/eagen_calc.sv
module eagen_calc
  import eagen_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     base,
  input  logic [DW-1:0]     index,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        scale,
  input  logic [1:0]        size,
  output logic [DW-1:0]     value,
  output logic              is_addr,
  output logic              legal,
  output logic              need_fetch,
  output logic              wb_en,
  output logic [DW-1:0]     wb_value
);

  logic [DW-1:0] imm_sx;
  logic [DW-1:0] imm_zx;
  logic [DW-1:0] step;
  logic [DW-1:0] idx_shift;
  logic [DW-1:0] base_up;
  logic [DW-1:0] base_dn;

  always_comb begin
    imm_sx    = DW'($signed(imm));
    imm_zx    = DW'(imm);
    step      = DW'(1) << size;
    idx_shift = index << scale;
    base_up   = base + step;
    base_dn   = base - step;
  end

  always_comb begin
    value      = '0;
    is_addr    = 1'b1;
    legal      = 1'b1;
    need_fetch = 1'b0;
    wb_en      = 1'b0;
    wb_value   = base_up;
    unique case (mode)
      MD_REG:  begin value = base;   is_addr = 1'b0; end
      MD_LIT:  begin value = imm_sx; is_addr = 1'b0; end
      MD_DISP: value = base + imm_sx;
      MD_BASE: value = base;
      MD_IDX:  value = base + index;
      MD_ABS:  value = imm_zx;
      MD_PTR:  begin value = base; need_fetch = 1'b1; end
      MD_PINC: begin value = base;    wb_en = 1'b1; wb_value = base_up; end
      MD_PDEC: begin value = base_dn; wb_en = 1'b1; wb_value = base_dn; end
      MD_SCL:  value = base + idx_shift + imm_sx;
      default: begin legal = 1'b0; is_addr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/eagen_ctrl.sv
module eagen_ctrl
  import eagen_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          legal,
  input  logic          need_fetch,
  input  logic [DW-1:0] calc_value,
  input  logic          calc_is_addr,
  output logic          mem_req_valid,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          out_valid,
  output logic [DW-1:0] out_value,
  output logic          out_is_addr,
  output logic          out_illegal
);

  eag_state_e st;

  assign in_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      out_valid     <= 1'b0;
      out_value     <= '0;
      out_is_addr   <= 1'b0;
      out_illegal   <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            if (!legal) begin
              out_valid   <= 1'b1;
              out_illegal <= 1'b1;
              out_value   <= '0;
              out_is_addr <= 1'b0;
            end else if (need_fetch) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= calc_value;
              st            <= ST_WAIT;
            end else begin
              out_valid   <= 1'b1;
              out_illegal <= 1'b0;
              out_value   <= calc_value;
              out_is_addr <= calc_is_addr;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            out_valid   <= 1'b1;
            out_illegal <= 1'b0;
            out_value   <= mem_rsp_data;
            out_is_addr <= 1'b1;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  single_cycle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && legal && !need_fetch) |=> (out_valid && !out_illegal && in_ready));

  // R5
  fetch_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !in_ready);

  // R5
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R5
  fetch_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && mem_rsp_valid) |=> (out_valid && out_is_addr && (out_value == $past(mem_rsp_data))));

  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !legal) |=> (out_valid && out_illegal && (out_value == '0) && !mem_req_valid));

  // R9
  idle_rsp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid && mem_rsp_valid) |=> !out_valid);

endmodule

// File: rtl/eagen_top.sv
module eagen_top
  import eagen_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 16,
  parameter int unsigned IMM_W = 16,
  localparam int unsigned IW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_mode,
  input  logic [IW-1:0]    in_ra,
  input  logic [IW-1:0]    in_rb,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [1:0]       in_scale,
  input  logic [1:0]       in_size,
  input  logic             rf_we,
  input  logic [IW-1:0]    rf_widx,
  input  logic [DW-1:0]    rf_wdata,
  output logic             mem_req_valid,
  output logic [DW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             out_valid,
  output logic [DW-1:0]    out_value,
  output logic             out_is_addr,
  output logic             out_illegal
);

  logic [DW-1:0] base_val;
  logic [DW-1:0] index_val;
  logic [DW-1:0] calc_value;
  logic          calc_is_addr;
  logic          calc_legal;
  logic          calc_fetch;
  logic          calc_wb_en;
  logic [DW-1:0] calc_wb_value;
  logic          accept;
  logic          se_we;

  assign accept = in_valid && in_ready;
  assign se_we  = accept && calc_wb_en;

  eagen_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .ra_idx   (in_ra),
    .rb_idx   (in_rb),
    .ra_data  (base_val),
    .rb_data  (index_val),
    .se_we    (se_we),
    .se_idx   (in_ra),
    .se_data  (calc_wb_value),
    .ext_we   (rf_we),
    .ext_idx  (rf_widx),
    .ext_data (rf_wdata)
  );

  eagen_calc #(.DW(DW), .IMM_W(IMM_W)) u_calc (
    .mode       (in_mode),
    .base       (base_val),
    .index      (index_val),
    .imm        (in_imm),
    .scale      (in_scale),
    .size       (in_size),
    .value      (calc_value),
    .is_addr    (calc_is_addr),
    .legal      (calc_legal),
    .need_fetch (calc_fetch),
    .wb_en      (calc_wb_en),
    .wb_value   (calc_wb_value)
  );

  eagen_ctrl #(.DW(DW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .legal         (calc_legal),
    .need_fetch    (calc_fetch),
    .calc_value    (calc_value),
    .calc_is_addr  (calc_is_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_value     (out_value),
    .out_is_addr   (out_is_addr),
    .out_illegal   (out_illegal)
  );

  // R6
  step_write_mode_chk: assert property (@(posedge clk) disable iff (rst)
    se_we |-> ((in_mode == MD_PINC) || (in_mode == MD_PDEC)));

  // R6
  step_base_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (in_mode == MD_PINC) && !(rf_we && (rf_widx == in_ra)))
      |=> (u_rf.regs[$past(in_ra)] == $past(base_val) + (DW'(1) << $past(in_size))));

endmodule

// File: tb/eagen_top_tb.sv
module eagen_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 32;
  localparam int NREG  = 16;
  localparam int IMM_W = 16;
  localparam int IW    = 4;
  localparam int FETCH_LAT = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [3:0]       in_mode = '0;
  logic [IW-1:0]    in_ra = '0;
  logic [IW-1:0]    in_rb = '0;
  logic [IMM_W-1:0] in_imm = '0;
  logic [1:0]       in_scale = '0;
  logic [1:0]       in_size = '0;
  logic             rf_we = 1'b0;
  logic [IW-1:0]    rf_widx = '0;
  logic [DW-1:0]    rf_wdata = '0;
  logic             mem_req_valid;
  logic [DW-1:0]    mem_req_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [DW-1:0]    mem_rsp_data = '0;
  logic             out_valid;
  logic [DW-1:0]    out_value;
  logic             out_is_addr;
  logic             out_illegal;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  logic [DW-1:0] shadow [NREG];
  logic          got_valid;
  logic [DW-1:0] got_value;
  logic          got_addr;
  logic          got_ill;

  always #(CLK_PERIOD/2) clk = ~clk;

  eagen_top #(.DW(DW), .NREG(NREG), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm),
    .in_scale(in_scale), .in_size(in_size), .rf_we(rf_we), .rf_widx(rf_widx),
    .rf_wdata(rf_wdata), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
    .out_value(out_value), .out_is_addr(out_is_addr), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_val(input string tag, input logic [DW-1:0] exp_v, input logic exp_addr);
    check(got_valid && !got_ill, {tag, " valid"}, DW'({got_valid, got_ill}), DW'(2'b10));
    check(got_value == exp_v, {tag, " value"}, got_value, exp_v);
    check(got_addr == exp_addr, {tag, " is_addr"}, DW'(got_addr), DW'(exp_addr));
  endtask

  task automatic wr_reg(input logic [IW-1:0] idx, input logic [DW-1:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_widx = idx; rf_wdata = val;
    @(posedge clk); #1;
    rf_we = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic req(input logic [3:0] m, input logic [IW-1:0] ra, input logic [IW-1:0] rb,
                     input logic [IMM_W-1:0] imm, input logic [1:0] sc, input logic [1:0] sz);
    @(negedge clk);
    in_mode = m; in_ra = ra; in_rb = rb; in_imm = imm; in_scale = sc; in_size = sz;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    got_valid = out_valid; got_value = out_value; got_addr = out_is_addr; got_ill = out_illegal;
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 reset in_ready", DW'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset out_valid", DW'(out_valid), 0);
    check(mem_req_valid == 1'b0, "R1 reset mem_req_valid", DW'(mem_req_valid), 0);
  endtask

  task automatic t_operand();
    req(4'd0, 4'd3, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R2 register operand", shadow[3], 1'b0);
    check(in_ready, "R1 ready after single-cycle", DW'(in_ready), 1);
    req(4'd1, 4'd0, 4'd0, 16'hFFF0, 2'd0, 2'd0);
    check_val("R2 literal sign-extended", 32'hFFFF_FFF0, 1'b0);
  endtask

  task automatic t_simple();
    req(4'd2, 4'd3, 4'd0, 16'hFFF0, 2'd0, 2'd0);
    check_val("R3 displacement negative", shadow[3] - 32'd16, 1'b1);
    req(4'd2, 4'd3, 4'd0, 16'h0123, 2'd0, 2'd0);
    check_val("R3 displacement positive", shadow[3] + 32'h123, 1'b1);
    req(4'd3, 4'd5, 4'd0, 16'h7777, 2'd0, 2'd0);
    check_val("R3 base only", shadow[5], 1'b1);
    req(4'd5, 4'd5, 4'd0, 16'h8004, 2'd0, 2'd0);
    check_val("R3 absolute zero-extended", 32'h0000_8004, 1'b1);
  endtask

  task automatic t_index();
    req(4'd4, 4'd3, 4'd5, 16'h0, 2'd0, 2'd0);
    check_val("R4 base plus index", shadow[3] + shadow[5], 1'b1);
    for (int s = 0; s < 4; s++) begin
      req(4'd9, 4'd3, 4'd5, 16'hFFFC, 2'(s), 2'd0);
      check_val($sformatf("R4 scaled x%0d", 1 << s), shadow[3] + (shadow[5] << s) - 32'd4, 1'b1);
    end
  endtask

  task automatic t_step();
    logic [DW-1:0] old;
    old = shadow[7];
    req(4'd7, 4'd7, 4'd0, 16'h0, 2'd0, 2'd2);
    check_val("R6 post-increment address", old, 1'b1);
    shadow[7] = old + 32'd4;
    req(4'd0, 4'd7, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R6 post-increment base", shadow[7], 1'b0);
    old = shadow[7];
    req(4'd8, 4'd7, 4'd0, 16'h0, 2'd0, 2'd3);
    check_val("R6 pre-decrement address", old - 32'd8, 1'b1);
    shadow[7] = old - 32'd8;
    req(4'd0, 4'd7, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R6 pre-decrement base", shadow[7], 1'b0);
    // R6 across zero: base 2, size 4 bytes, decrement wraps
    old = shadow[11];
    req(4'd8, 4'd11, 4'd0, 16'h0, 2'd0, 2'd2);
    check_val("R6 pre-decrement wrap", old - 32'd4, 1'b1);
    shadow[11] = old - 32'd4;
    req(4'd0, 4'd11, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R6 wrap base", shadow[11], 1'b0);
  endtask

  task automatic t_pointer();
    logic [DW-1:0] cap_addr;
    logic [DW-1:0] ptr_data;
    @(negedge clk);
    in_mode = 4'd6; in_ra = 4'd5; in_rb = '0; in_imm = '0; in_scale = '0; in_size = '0;
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(mem_req_valid, "R5 fetch issued", DW'(mem_req_valid), 1);
    check(mem_req_addr == shadow[5], "R5 fetch address", mem_req_addr, shadow[5]);
    check(!in_ready, "R5 stall while waiting", DW'(in_ready), 0);
    check(!out_valid, "R5 no early result", DW'(out_valid), 0);
    cap_addr = mem_req_addr;
    ptr_data = cap_addr ^ 32'h5A00_0F00;
    for (int i = 0; i < FETCH_LAT; i++) begin
      @(negedge clk);
      check(!mem_req_valid, "R5 single request pulse", DW'(mem_req_valid), 0);
      check(!in_ready, "R5 stall held", DW'(in_ready), 0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = ptr_data;
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    got_valid = out_valid; got_value = out_value; got_addr = out_is_addr; got_ill = out_illegal;
    check_val("R5 pointer result", ptr_data, 1'b1);
    check(in_ready, "R5 ready after response", DW'(in_ready), 1);
  endtask

  task automatic t_illegal();
    logic [DW-1:0] old;
    old = shadow[7];
    for (int c = 10; c < 16; c += 5) begin
      req(4'(c), 4'd7, 4'd5, 16'h0010, 2'd1, 2'd2);
      check(got_valid && got_ill, $sformatf("R7 code %0d flagged", c), DW'({got_valid, got_ill}), DW'(2'b11));
      check(got_value == '0, "R7 illegal value zero", got_value, '0);
      check(!mem_req_valid, "R7 no fetch", DW'(mem_req_valid), 0);
    end
    req(4'd0, 4'd7, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R7 base untouched", old, 1'b0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] old;
    old = shadow[9];
    @(negedge clk);
    in_mode = 4'd7; in_ra = 4'd9; in_rb = '0; in_imm = '0; in_scale = '0; in_size = 2'd0;
    in_valid = 1'b1;
    rf_we = 1'b1; rf_widx = 4'd9; rf_wdata = 32'h5555_5555;
    @(posedge clk); #1;
    in_valid = 1'b0; rf_we = 1'b0;
    shadow[9] = old + 32'd1;
    req(4'd0, 4'd9, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R8 stepping write wins", shadow[9], 1'b0);
    old = shadow[9];
    @(negedge clk);
    in_mode = 4'd7; in_ra = 4'd9; in_size = 2'd1;
    in_valid = 1'b1;
    rf_we = 1'b1; rf_widx = 4'd10; rf_wdata = 32'hABCD_0123;
    @(posedge clk); #1;
    in_valid = 1'b0; rf_we = 1'b0;
    shadow[9] = old + 32'd2;
    shadow[10] = 32'hABCD_0123;
    req(4'd0, 4'd9, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R8 stepping write other reg", shadow[9], 1'b0);
    req(4'd0, 4'd10, 4'd0, 16'h0, 2'd0, 2'd0);
    check_val("R8 external write other reg", shadow[10], 1'b0);
  endtask

  task automatic t_idle_rsp();
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R9 idle response ignored", DW'(out_valid), 0);
    check(in_ready, "R9 still ready", DW'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < NREG; i++) wr_reg(4'(i), 32'h0100_0000 + 32'(i) * 32'h10);
    wr_reg(4'd3, 32'h0000_1000);
    wr_reg(4'd5, 32'h8000_0040);
    wr_reg(4'd7, 32'h0000_0200);
    wr_reg(4'd9, 32'hFFFF_FFFF);
    wr_reg(4'd11, 32'h0000_0002);
    t_operand();
    t_simple();
    t_index();
    t_step();
    t_pointer();
    t_illegal();
    t_collide();
    t_idle_rsp();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule